// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of one eight-input priority interrupt controller. It has two addresses. Writes carry the initialization word sequence and the operational commands. Reads return the pending-request register, the in-service register or the mask register, or the result of a poll. The request and in-service registers themselves live in a neighbouring block. The decoder reads their current values and issues one-cycle clear pulses back to them. The same neighbour supplies the resolver's current winner, which the poll path uses.

The decoder owns the interrupt mask, the vector base and the rotation offset that the resolver uses to rank inputs. It also owns the mode flags: special nesting, automatic end-of-interrupt, rotate on automatic end-of-interrupt, special mask, read select and poll pending. A separate trigger-mode register has its own write strobe. Its written value is ANDed with a keep-mask that a parameter selects, one value for the primary role and another for the secondary role.

Top module: `pic_cmd_decoder`

## Requirements
- R1: A write to address 0 with data bit 4 set starts initialization. In the next cycle the mask, vector base, rotation offset and every mode flag (including read select, poll and special mask) read zero. Both `isr_clr` and `irr_clr` pulse 0xFF for one cycle. Data bit 0 is recorded as "fourth word wanted".
- R2: After initialization starts, the first address-1 write loads `vec_base` from data bits 7..3. The second address-1 write is discarded. It leads to a mode-word step only if the fourth word was wanted; otherwise it returns to normal operation. The mode word sets `nest_mode` from bit 4 and `auto_eoi` from bit 1, then returns to normal operation.
- R3: In normal operation an address-1 write loads `imr` with the whole data byte.
- R4: An address-0 write with bit 3 set and bit 4 clear is a read/poll command. Bit 2 set arms poll. When bit 1 is set, bit 0 selects the read source (1 = in-service, 0 = request); otherwise the selection is kept. When bit 6 is set, bit 5 loads `spec_mask`; otherwise the flag is kept.
- R5: An address-0 write with bits 4 and 3 clear is a command whose code is data bits 7..5. Codes 1 and 5 clear the highest-priority set in-service bit. Rank starts at input `prio_offset` and rises modulo 8. Code 5 also sets the offset to that input plus one, modulo 8. With no in-service bit set, neither code clears anything or moves the offset.
- R6: Codes 3 and 7 clear the in-service bit whose index is data bits 2..0. Code 7 also sets the offset to that index plus one, modulo 8. Code 3 leaves the offset unchanged.
- R7: Code 6 sets the offset to data bits 2..0 plus one, modulo 8, and clears nothing. Codes 0 and 4 load `rot_auto_eoi` from data bit 7. Code 2 changes no output.
- R8: Read data is registered and appears in the cycle after the read strobe. Address 0 returns the in-service or request register, as selected. Address 1 returns the mask.
- R9: A read while poll is armed returns the winner index in bits 2..0 with the upper bits zero. In the next cycle it pulses `irr_clr` and `isr_clr` at that index, and it disarms poll. With no valid winner it returns 7 and clears nothing.
- R10: A trigger-mode write loads the data ANDed with the keep-mask: 0xF8 in the primary role and 0xDE in the secondary role.
- R11: After reset every register output is zero and no clear pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| trig_wr | input | 1 | Trigger-mode register write strobe |
| irr | input | 8 | Current pending-request register |
| isr | input | 8 | Current in-service register |
| win_vld | input | 1 | Resolver has a winner |
| win_idx | input | 3 | Resolver winner index |
| imr | output | 8 | Interrupt mask register |
| vec_base | output | 5 | Vector base (upper five bits of the vector) |
| nest_mode | output | 1 | Special nesting mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_auto_eoi | output | 1 | Rotate on automatic end-of-interrupt |
| spec_mask | output | 1 | Special mask mode |
| prio_offset | output | 3 | Input that currently holds top priority |
| isr_clr | output | 8 | One-cycle in-service clear pulses |
| irr_clr | output | 8 | One-cycle request clear pulses |
| trig_mode | output | 8 | Trigger-mode register |
| rdata | output | 8 | Registered read data |

## Verification
The bench rotates the offset and then issues non-specific end-of-interrupt commands. A decoder that ranked in-service bits from input 0 instead of from the offset would clear the wrong bit. The bench also drives an empty in-service register. A decoder that moved the offset there would fail. Offset codes are driven at index 7 to catch a missing modulo-8 wrap. The initialization sequence is run both with and without the fourth word. A decoder that mis-counted steps would load a configuration byte into the mask, or miss the mode word. Poll is exercised with and without a winner, and then checked as disarmed. A decoder that kept poll armed would return a poll result where the mask should appear.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

   // Initialization word sequencer steps
   typedef enum logic [1:0] {
      INIT_RUN  = 2'd0,
      INIT_BASE = 2'd1,
      INIT_SKIP = 2'd2,
      INIT_MODE = 2'd3
   } init_step_t;

   // Operation codes carried in data bits 7..5 of an address-0 command write
   typedef enum logic [2:0] {
      OP_ROT_OFF     = 3'd0,
      OP_EOI_TOP     = 3'd1,
      OP_NONE        = 3'd2,
      OP_EOI_IDX     = 3'd3,
      OP_ROT_ON      = 3'd4,
      OP_EOI_TOP_ROT = 3'd5,
      OP_SET_LOW     = 3'd6,
      OP_EOI_IDX_ROT = 3'd7
   } op_code_t;

   typedef struct packed {
      logic nest;
      logic auto_eoi;
      logic rot_auto;
      logic spec_mask;
      logic rd_isr;
      logic poll;
   } mode_t;

endpackage

// File: rtl/pic_isr_pick.sv
module pic_isr_pick #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  isr,
   input  logic [IW-1:0] offset,
   output logic          found,
   output logic [IW-1:0] idx
);
   logic [N-1:0] rot;

   // rot[k] is the in-service bit that ranks k-th from the offset
   for (genvar g = 0; g < N; g++) begin : g_rot
      assign rot[g] = isr[offset + IW'(g)];
   end

   always_comb begin
      found = |rot;
      idx   = offset;
      for (int k = N - 1; k >= 0; k--) begin
         if (rot[k]) idx = offset + IW'(k);
      end
   end

   // R5: a reported pick always names a set in-service bit
   always_comb begin
      if (found) a_r5_pick_is_set: assert (isr[idx]);
   end
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
   import pic_cmd_pkg::*;
#(
   parameter int N  = 8,
   parameter int DW = 8,
   parameter int IW = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic           rd,
   input  logic           addr,
   input  logic [DW-1:0]  wdata,
   input  logic           pick_found,
   input  logic [IW-1:0]  pick_idx,
   output logic [N-1:0]   imr,
   output logic [DW-IW-1:0] base,
   output mode_t          mode,
   output logic [IW-1:0]  offset,
   output logic           init_hit,
   output logic [N-1:0]   eoi_clr
);
   init_step_t step;
   logic       need4;
   logic       cmd_a0, rw_cmd, op_cmd, cfg_wr;
   op_code_t   op;
   logic [IW-1:0] sel_idx;

   assign cmd_a0   = wr && !addr;
   assign init_hit = cmd_a0 && wdata[4];
   assign rw_cmd   = cmd_a0 && !wdata[4] && wdata[3];
   assign op_cmd   = cmd_a0 && !wdata[4] && !wdata[3];
   assign cfg_wr   = wr && addr;
   assign op       = op_code_t'(wdata[7:5]);
   assign sel_idx  = wdata[IW-1:0];

   always_comb begin
      eoi_clr = '0;
      if (op_cmd) begin
         case (op)
            OP_EOI_TOP, OP_EOI_TOP_ROT: if (pick_found) eoi_clr[pick_idx] = 1'b1;
            OP_EOI_IDX, OP_EOI_IDX_ROT: eoi_clr[sel_idx] = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step   <= INIT_RUN;
         need4  <= 1'b0;
         imr    <= '0;
         base   <= '0;
         mode   <= '0;
         offset <= '0;
      end else if (init_hit) begin
         step   <= INIT_BASE;
         need4  <= wdata[0];
         imr    <= '0;
         base   <= '0;
         mode   <= '0;
         offset <= '0;
      end else begin
         if (rd && mode.poll) mode.poll <= 1'b0;
         if (rw_cmd) begin
            if (wdata[2]) mode.poll      <= 1'b1;
            if (wdata[1]) mode.rd_isr    <= wdata[0];
            if (wdata[6]) mode.spec_mask <= wdata[5];
         end
         if (op_cmd) begin
            case (op)
               OP_ROT_OFF, OP_ROT_ON: mode.rot_auto <= wdata[7];
               OP_EOI_TOP_ROT: if (pick_found) offset <= pick_idx + IW'(1);
               OP_EOI_IDX_ROT, OP_SET_LOW: offset <= sel_idx + IW'(1);
               default: ;
            endcase
         end
         if (cfg_wr) begin
            case (step)
               INIT_RUN:  imr <= wdata[N-1:0];
               INIT_BASE: begin
                  base <= wdata[DW-1:IW];
                  step <= INIT_SKIP;
               end
               INIT_SKIP: step <= need4 ? INIT_MODE : INIT_RUN;
               INIT_MODE: begin
                  mode.nest     <= wdata[4];
                  mode.auto_eoi <= wdata[1];
                  step          <= INIT_RUN;
               end
               default: step <= INIT_RUN;
            endcase
         end
      end
   end

   a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      init_hit |=> (imr == '0 && base == '0 && offset == '0 && mode == '0));

   a_r2_base_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !init_hit && step == INIT_BASE)
      |=> (base == $past(wdata[DW-1:IW]) && step == INIT_SKIP));

   a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && step == INIT_RUN) |=> imr == $past(wdata[N-1:0]));

   a_r9_poll_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && mode.poll && !wr) |=> !mode.poll);
endmodule

// File: rtl/pic_rd_port.sv
module pic_rd_port #(
   parameter int N  = 8,
   parameter int DW = 8,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd,
   input  logic          addr,
   input  logic          poll,
   input  logic          rd_isr,
   input  logic [N-1:0]  isr,
   input  logic [N-1:0]  irr,
   input  logic [N-1:0]  imr,
   input  logic          win_vld,
   input  logic [IW-1:0] win_idx,
   output logic [DW-1:0] rdata,
   output logic [N-1:0]  poll_clr
);
   localparam logic [DW-1:0] NO_WINNER = DW'(N - 1);

   always_comb begin
      poll_clr = '0;
      if (rd && poll && win_vld) poll_clr[win_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         if (poll)      rdata <= win_vld ? {{(DW-IW){1'b0}}, win_idx} : NO_WINNER;
         else if (addr) rdata <= DW'(imr);
         else           rdata <= DW'(rd_isr ? isr : irr);
      end
   end

   a_r8_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr && !poll) |=> rdata == DW'($past(imr)));

   a_r9_poll_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && poll && !win_vld) |=> rdata == NO_WINNER);
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
   import pic_cmd_pkg::*;
#(
   parameter int N_IN     = 8,
   parameter int DW       = 8,
   parameter bit IS_SLAVE = 1'b0,
   parameter logic [7:0] PRIMARY_KEEP   = 8'hF8,
   parameter logic [7:0] SECONDARY_KEEP = 8'hDE,
   localparam int IW = $clog2(N_IN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   input  logic          wr,
   input  logic          rd,
   input  logic          trig_wr,
   input  logic [N_IN-1:0] irr,
   input  logic [N_IN-1:0] isr,
   input  logic          win_vld,
   input  logic [IW-1:0] win_idx,
   output logic [N_IN-1:0] imr,
   output logic [DW-IW-1:0] vec_base,
   output logic          nest_mode,
   output logic          auto_eoi,
   output logic          rot_auto_eoi,
   output logic          spec_mask,
   output logic [IW-1:0] prio_offset,
   output logic [N_IN-1:0] isr_clr,
   output logic [N_IN-1:0] irr_clr,
   output logic [DW-1:0] trig_mode,
   output logic [DW-1:0] rdata
);
   if (N_IN != DW) begin : g_bad_width
      $error("pic_cmd_decoder: N_IN must equal DW");
   end
   if (N_IN != 8) begin : g_bad_count
      $error("pic_cmd_decoder: command fields assume eight inputs");
   end

   logic [DW-1:0] trig_keep;
   if (IS_SLAVE) begin : g_keep_secondary
      assign trig_keep = DW'(SECONDARY_KEEP);
   end else begin : g_keep_primary
      assign trig_keep = DW'(PRIMARY_KEEP);
   end

   mode_t           mode;
   logic            pick_found, init_hit;
   logic [IW-1:0]   pick_idx;
   logic [N_IN-1:0] eoi_clr, poll_clr;

   pic_isr_pick #(.N(N_IN)) u_pick (
      .isr    (isr),
      .offset (prio_offset),
      .found  (pick_found),
      .idx    (pick_idx)
   );

   pic_cfg_regs #(.N(N_IN), .DW(DW)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr),
      .rd         (rd),
      .addr       (addr),
      .wdata      (wdata),
      .pick_found (pick_found),
      .pick_idx   (pick_idx),
      .imr        (imr),
      .base       (vec_base),
      .mode       (mode),
      .offset     (prio_offset),
      .init_hit   (init_hit),
      .eoi_clr    (eoi_clr)
   );

   pic_rd_port #(.N(N_IN), .DW(DW)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (rd),
      .addr     (addr),
      .poll     (mode.poll),
      .rd_isr   (mode.rd_isr),
      .isr      (isr),
      .irr      (irr),
      .imr      (imr),
      .win_vld  (win_vld),
      .win_idx  (win_idx),
      .rdata    (rdata),
      .poll_clr (poll_clr)
   );

   assign nest_mode    = mode.nest;
   assign auto_eoi     = mode.auto_eoi;
   assign rot_auto_eoi = mode.rot_auto;
   assign spec_mask    = mode.spec_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_clr   <= '0;
         irr_clr   <= '0;
         trig_mode <= '0;
      end else begin
         isr_clr <= init_hit ? '1 : (eoi_clr | poll_clr);
         irr_clr <= init_hit ? '1 : poll_clr;
         if (trig_wr) trig_mode <= wdata & trig_keep;
      end
   end

   a_r10_trig_masked: assert property (@(posedge clk) disable iff (!rst_n)
      trig_wr |=> trig_mode == ($past(wdata) & trig_keep));

   a_r5_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !rd && !(!addr && wdata[4])) |=> $onehot0(isr_clr));

   a_r1_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !addr && wdata[4]) |=> (isr_clr == '1 && irr_clr == '1));
endmodule

// File: tb/pic_cmd_decoder_test.sv
module pic_cmd_decoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr = 1'b0;
   logic [7:0] wdata = '0;
   logic       wr = 1'b0, rd = 1'b0, trig_wr = 1'b0;
   logic [7:0] irr_in = '0, isr_in = '0;
   logic       win_vld = 1'b0;
   logic [2:0] win_idx = '0;

   logic [7:0] imr, isr_clr, irr_clr, trig_mode, rdata;
   logic [4:0] vec_base;
   logic       nest_mode, auto_eoi, rot_auto_eoi, spec_mask;
   logic [2:0] prio_offset;

   logic [7:0] s_imr, s_isr_clr, s_irr_clr, s_trig, s_rdata;
   logic [4:0] s_base;
   logic       s_nest, s_aeoi, s_rot, s_smask;
   logic [2:0] s_off;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   pic_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
      .trig_wr(trig_wr), .irr(irr_in), .isr(isr_in), .win_vld(win_vld),
      .win_idx(win_idx), .imr(imr), .vec_base(vec_base), .nest_mode(nest_mode),
      .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi), .spec_mask(spec_mask),
      .prio_offset(prio_offset), .isr_clr(isr_clr), .irr_clr(irr_clr),
      .trig_mode(trig_mode), .rdata(rdata)
   );

   pic_cmd_decoder #(.IS_SLAVE(1'b1)) uut_slv (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
      .trig_wr(trig_wr), .irr(irr_in), .isr(isr_in), .win_vld(win_vld),
      .win_idx(win_idx), .imr(s_imr), .vec_base(s_base), .nest_mode(s_nest),
      .auto_eoi(s_aeoi), .rot_auto_eoi(s_rot), .spec_mask(s_smask),
      .prio_offset(s_off), .isr_clr(s_isr_clr), .irr_clr(s_irr_clr),
      .trig_mode(s_trig), .rdata(s_rdata)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic a);
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic t_reset;
      check("R11 imr", imr, 8'h00);
      check("R11 base", {3'b0, vec_base}, 8'h00);
      check("R11 flags", {4'b0, nest_mode, auto_eoi, rot_auto_eoi, spec_mask}, 8'h00);
      check("R11 offset", {5'b0, prio_offset}, 8'h00);
      check("R11 clr", isr_clr | irr_clr, 8'h00);
      check("R11 rdata", rdata, 8'h00);
   endtask

   task automatic t_init_four;
      wr_reg(1'b0, 8'h11);
      check("R1 isr_clr", isr_clr, 8'hFF);
      check("R1 irr_clr", irr_clr, 8'hFF);
      wr_reg(1'b1, 8'h4D);
      check("R2 base", {3'b0, vec_base}, 8'h09);
      check("R2 imr untouched", imr, 8'h00);
      wr_reg(1'b1, 8'hAA);
      check("R2 third ignored", imr, 8'h00);
      wr_reg(1'b1, 8'h12);
      check("R2 mode word", {6'b0, nest_mode, auto_eoi}, 8'h03);
      check("R2 mode word imr", imr, 8'h00);
      wr_reg(1'b1, 8'h5A);
      check("R3 mask", imr, 8'h5A);
   endtask

   task automatic t_init_three;
      wr_reg(1'b0, 8'h10);
      check("R1 flags cleared", {6'b0, nest_mode, auto_eoi}, 8'h00);
      check("R1 mask cleared", imr, 8'h00);
      wr_reg(1'b1, 8'h20);
      check("R2 base", {3'b0, vec_base}, 8'h04);
      wr_reg(1'b1, 8'hFF);
      check("R2 skip word", imr, 8'h00);
      wr_reg(1'b1, 8'h33);
      check("R3 mask after three words", imr, 8'h33);
      check("R2 no mode word", {6'b0, nest_mode, auto_eoi}, 8'h00);
   endtask

   task automatic t_reads;
      isr_in = 8'h24; irr_in = 8'h81;
      rd_reg(1'b0);
      check("R8 request read", rdata, 8'h81);
      wr_reg(1'b0, 8'h0B);
      rd_reg(1'b0);
      check("R4 select isr", rdata, 8'h24);
      wr_reg(1'b0, 8'h08);
      rd_reg(1'b0);
      check("R4 select kept", rdata, 8'h24);
      wr_reg(1'b0, 8'h0A);
      rd_reg(1'b0);
      check("R4 select irr", rdata, 8'h81);
      rd_reg(1'b1);
      check("R8 mask read", rdata, 8'h33);
      wr_reg(1'b0, 8'h68);
      check("R4 special mask on", {7'b0, spec_mask}, 8'h01);
      wr_reg(1'b0, 8'h28);
      check("R4 special mask kept", {7'b0, spec_mask}, 8'h01);
      wr_reg(1'b0, 8'h48);
      check("R4 special mask off", {7'b0, spec_mask}, 8'h00);
   endtask

   task automatic t_nonspecific;
      isr_in = 8'h24;
      wr_reg(1'b0, 8'h20);
      check("R5 clear from 0", isr_clr, 8'h04);
      check("R5 irr untouched", irr_clr, 8'h00);
      wr_reg(1'b0, 8'hC2);
      check("R7 set offset", {5'b0, prio_offset}, 8'h03);
      check("R7 no clear", isr_clr, 8'h00);
      wr_reg(1'b0, 8'h20);
      check("R5 rotated rank", isr_clr, 8'h20);
      wr_reg(1'b0, 8'hA0);
      check("R5 rotate clear", isr_clr, 8'h20);
      check("R5 rotate offset", {5'b0, prio_offset}, 8'h06);
      wr_reg(1'b0, 8'hA0);
      check("R5 wrap rank", isr_clr, 8'h04);
      check("R5 wrap offset", {5'b0, prio_offset}, 8'h03);
      isr_in = 8'h00;
      wr_reg(1'b0, 8'h20);
      check("R5 empty clear", isr_clr, 8'h00);
      wr_reg(1'b0, 8'hA0);
      check("R5 empty offset", {5'b0, prio_offset}, 8'h03);
   endtask

   task automatic t_specific;
      wr_reg(1'b0, 8'h63);
      check("R6 specific clear", isr_clr, 8'h08);
      check("R6 offset kept", {5'b0, prio_offset}, 8'h03);
      wr_reg(1'b0, 8'hE7);
      check("R6 rotate clear", isr_clr, 8'h80);
      check("R6 offset wrap", {5'b0, prio_offset}, 8'h00);
      wr_reg(1'b0, 8'hC5);
      check("R7 offset", {5'b0, prio_offset}, 8'h06);
      wr_reg(1'b0, 8'hC7);
      check("R7 offset wrap", {5'b0, prio_offset}, 8'h00);
   endtask

   task automatic t_rot_flag;
      wr_reg(1'b0, 8'h80);
      check("R7 rotate flag on", {7'b0, rot_auto_eoi}, 8'h01);
      wr_reg(1'b0, 8'h40);
      check("R7 nop clear", isr_clr, 8'h00);
      check("R7 nop offset", {5'b0, prio_offset}, 8'h00);
      check("R7 nop flags", {4'b0, nest_mode, auto_eoi, rot_auto_eoi, spec_mask}, 8'h02);
      check("R7 nop mask", imr, 8'h33);
      wr_reg(1'b0, 8'h00);
      check("R7 rotate flag off", {7'b0, rot_auto_eoi}, 8'h00);
   endtask

   task automatic t_poll;
      win_vld = 1'b1; win_idx = 3'd5;
      wr_reg(1'b0, 8'h0C);
      rd_reg(1'b1);
      check("R9 poll value", rdata, 8'h05);
      check("R9 poll irr clear", irr_clr, 8'h20);
      check("R9 poll isr clear", isr_clr, 8'h20);
      rd_reg(1'b1);
      check("R9 poll disarmed", rdata, 8'h33);
      check("R9 no second clear", irr_clr, 8'h00);
      win_vld = 1'b0;
      wr_reg(1'b0, 8'h0C);
      rd_reg(1'b0);
      check("R9 no winner", rdata, 8'h07);
      check("R9 no winner clear", irr_clr | isr_clr, 8'h00);
   endtask

   task automatic t_trig;
      @(negedge clk);
      wdata = 8'hFF; trig_wr = 1'b1;
      @(negedge clk);
      trig_wr = 1'b0;
      check("R10 primary keep", trig_mode, 8'hF8);
      check("R10 secondary keep", s_trig, 8'hDE);
      @(negedge clk);
      wdata = 8'h21; trig_wr = 1'b1;
      @(negedge clk);
      trig_wr = 1'b0;
      check("R10 primary value", trig_mode, 8'h20);
      check("R10 secondary value", s_trig, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_init_four();
      t_init_three();
      t_reads();
      t_nonspecific();
      t_specific();
      t_rot_flag();
      t_poll();
      t_trig();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule